// File: doc/BRIEF.md
# SHA-256 Compression Round Stage

This block applies one SHA-256 compression round to a 256-bit working state. Each transfer carries eight 32-bit state words (a through h), the round constant for that round and the message schedule word for that round. From these the stage forms the two temporary sums and rotates the state. It then captures the eight new words in an output register.

The stage sits between an upstream producer and a downstream consumer, with a valid/ready handshake on each side. Its result register is one entry deep. While the consumer stalls, the stage keeps its result stable and refuses new input. When the consumer takes the result, the stage can accept a new word set in the same cycle. Several stages can therefore be chained, or one stage can be fed in a loop by an external round sequencer.

Top module: `sha_round_stage`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stage clears its result (`out_valid` is 0 after that edge). Coming out of reset, `in_ready` is 1.
- R2: The new `out_a` equals T1+T2. T1 is the sum of h, S1(e), Ch(e,f,g), the round constant and the schedule word. T2 is the sum of S0(a) and Maj(a,b,c). S1(x) is the XOR of x rotated right by 6, 11 and 25. S0(x) is the XOR of x rotated right by 2, 13 and 22. Ch(e,f,g) = (e&f)^(~e&g). Maj = (a&b)^(a&c)^(b&c).
- R3: The new `out_e` equals d+T1.
- R4: The other words move down one position: `out_b`=a, `out_c`=b, `out_d`=c, `out_f`=e, `out_g`=f, `out_h`=g.
- R5: Every addition wraps modulo 2^32, with the carry out of bit 31 discarded. This includes all-ones inputs.
- R6: An input accepted at a rising edge (`in_valid` and `in_ready` both 1) appears at the outputs with `out_valid` 1 right after that same edge, which is a latency of one cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and all eight output words keep their values at the next edge.
- R8: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.
- R9: When the result is taken (`out_valid` and `out_ready` both 1) and no input is accepted in that cycle, `out_valid` is 0 after the edge.
- R10: Each accepted input yields exactly one result, and results come out in the order the inputs were accepted. No result is lost or repeated.
- R11: Input words presented while `in_ready` is 0 have no effect on the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream word set is valid |
| in_ready | output | 1 | Stage can accept a word set this cycle |
| in_a | input | 32 | State word a |
| in_b | input | 32 | State word b |
| in_c | input | 32 | State word c |
| in_d | input | 32 | State word d |
| in_e | input | 32 | State word e |
| in_f | input | 32 | State word f |
| in_g | input | 32 | State word g |
| in_h | input | 32 | State word h |
| in_k | input | 32 | Round constant |
| in_w | input | 32 | Message schedule word |
| out_valid | output | 1 | Result register holds a valid result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_a | output | 32 | New state word a |
| out_b | output | 32 | New state word b |
| out_c | output | 32 | New state word c |
| out_d | output | 32 | New state word d |
| out_e | output | 32 | New state word e |
| out_f | output | 32 | New state word f |
| out_g | output | 32 | New state word g |
| out_h | output | 32 | New state word h |

## Verification
The hardest case to reach is the cycle in which a held result leaves and a new input enters on the same edge. This is also the only case in which a transfer could be silently dropped or repeated. The stimulus toggles `out_ready` and `in_valid` at random each cycle from a fixed seed, so this overlap occurs many times, along with long stalls. During stalls the input words keep changing, which checks that they are ignored. An ordered queue of model results catches any loss, duplication or reordering. Directed vectors add all-zero and all-ones word sets, plus a known first round of a real hash.

// File: rtl/sha_rnd_pkg.sv
package sha_rnd_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_WD  = 8;
  localparam int STATE_W = WORD_W * NUM_WD;

  // rotation amounts of the two big-sigma functions
  localparam int S1_R0 = 6;
  localparam int S1_R1 = 11;
  localparam int S1_R2 = 25;
  localparam int S0_R0 = 2;
  localparam int S0_R1 = 13;
  localparam int S0_R2 = 22;

  // word positions inside the packed state, a in the lowest slot
  localparam int IX_A = 0;
  localparam int IX_B = 1;
  localparam int IX_C = 2;
  localparam int IX_D = 3;
  localparam int IX_E = 4;
  localparam int IX_F = 5;
  localparam int IX_G = 6;
  localparam int IX_H = 7;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NUM_WD-1:0][WORD_W-1:0] state_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, S1_R0) ^ rotr(x, S1_R1) ^ rotr(x, S1_R2);
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, S0_R0) ^ rotr(x, S0_R1) ^ rotr(x, S0_R2);
  endfunction

  function automatic word_t choose(input word_t s, input word_t p, input word_t q);
    return (s & p) ^ (~s & q);
  endfunction

  function automatic word_t major(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction
endpackage

// File: rtl/sha_rnd_mix.sv
module sha_rnd_mix
  import sha_rnd_pkg::*;
(
  input  state_t cur,
  input  word_t  rk,
  input  word_t  sw,
  output state_t nxt
);
  word_t t1;
  word_t t2;

  // sums wrap at WORD_W bits by width of word_t
  always_comb begin
    t1 = cur[IX_H] + big_s1(cur[IX_E]) + choose(cur[IX_E], cur[IX_F], cur[IX_G]) + rk + sw;
    t2 = big_s0(cur[IX_A]) + major(cur[IX_A], cur[IX_B], cur[IX_C]);
  end

  assign nxt[IX_A] = t1 + t2;
  assign nxt[IX_E] = cur[IX_D] + t1;

  // plain shift of the remaining words down one slot
  for (genvar i = 1; i < NUM_WD; i++) begin : g_move
    if (i != IX_E) begin : g_cp
      assign nxt[i] = cur[i-1];
    end
  end
endmodule

// File: rtl/sha_rnd_slot.sv
module sha_rnd_slot #(
  parameter int DW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  logic          full_q;
  logic [DW-1:0] data_q;
  logic          take;

  assign up_ready = !full_q || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
    end else if (dn_ready) begin
      full_q <= 1'b0;
    end
  end

  // data register carries no reset so it maps onto plain flops
  always_ff @(posedge clk) begin
    if (take) data_q <= up_data;
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> dn_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));
  a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |-> !up_ready);
  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && !up_valid) |=> !dn_valid);
endmodule

// File: rtl/sha_round_stage.sv
module sha_round_stage
  import sha_rnd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  input  logic [31:0] in_c,
  input  logic [31:0] in_d,
  input  logic [31:0] in_e,
  input  logic [31:0] in_f,
  input  logic [31:0] in_g,
  input  logic [31:0] in_h,
  input  logic [31:0] in_k,
  input  logic [31:0] in_w,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_a,
  output logic [31:0] out_b,
  output logic [31:0] out_c,
  output logic [31:0] out_d,
  output logic [31:0] out_e,
  output logic [31:0] out_f,
  output logic [31:0] out_g,
  output logic [31:0] out_h
);
  state_t cur_st;
  state_t nxt_st;
  state_t res_st;

  assign cur_st[IX_A] = in_a;
  assign cur_st[IX_B] = in_b;
  assign cur_st[IX_C] = in_c;
  assign cur_st[IX_D] = in_d;
  assign cur_st[IX_E] = in_e;
  assign cur_st[IX_F] = in_f;
  assign cur_st[IX_G] = in_g;
  assign cur_st[IX_H] = in_h;

  sha_rnd_mix u_mix (
    .cur (cur_st),
    .rk  (in_k),
    .sw  (in_w),
    .nxt (nxt_st)
  );

  sha_rnd_slot #(.DW(STATE_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (nxt_st),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (res_st)
  );

  assign out_a = res_st[IX_A];
  assign out_b = res_st[IX_B];
  assign out_c = res_st[IX_C];
  assign out_d = res_st[IX_D];
  assign out_e = res_st[IX_E];
  assign out_f = res_st[IX_F];
  assign out_g = res_st[IX_G];
  assign out_h = res_st[IX_H];

  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_b == $past(in_a) && out_c == $past(in_b) &&
                                out_d == $past(in_c) && out_f == $past(in_e) &&
                                out_g == $past(in_f) && out_h == $past(in_g)));
  a_r1_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

// File: tb/sha_round_stage_tb.sv
module sha_round_stage_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [31:0] in_a = 0, in_b = 0, in_c = 0, in_d = 0, in_e = 0, in_f = 0, in_g = 0, in_h = 0;
  logic [31:0] in_k = 0, in_w = 0;
  logic [31:0] out_a, out_b, out_c, out_d, out_e, out_f, out_g, out_h;

  int n_chk = 0, n_fail = 0, n_in = 0, n_out = 0;
  bit done = 0;
  logic [255:0] q[$];
  logic [255:0] snap;
  bit hold_prev = 0;

  always #2 clk = ~clk;

  sha_round_stage u_dut (.*);

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  // model: {a..h} packed with a in the top word
  function automatic logic [255:0] model(input logic [255:0] s, input logic [31:0] k, input logic [31:0] w);
    logic [31:0] a, b, c, d, e, f, g, h, x1, x2;
    {a, b, c, d, e, f, g, h} = s;
    x1 = h + (rr(e, 25) ^ rr(e, 6) ^ rr(e, 11)) + ((g & ~e) | (f & e)) + w + k;
    x2 = (rr(a, 22) ^ rr(a, 2) ^ rr(a, 13)) + ((a & b) | (c & (a | b)));
    return {x2 + x1, a, b, c, d + x1, e, f, g};
  endfunction

  function automatic logic [255:0] outs();
    return {out_a, out_b, out_c, out_d, out_e, out_f, out_g, out_h};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // one cycle; called at a falling edge
  task automatic step(input bit rdy, input bit iv, input logic [255:0] st, input logic [31:0] k, input logic [31:0] w);
    bit ov, fo, fi, exp_ov;
    ov = out_valid;
    if (ov) begin
      if (q.size() == 0) chk(0, "R10 result with no pending input", outs(), '0);
      else chk(outs() == q[0], "R2 R3 R4 R5 result words", outs(), q[0]);
      if (hold_prev) chk(outs() == snap, "R7 R11 held words stable", outs(), snap);
    end
    snap = outs();
    out_ready = rdy;
    in_valid = iv;
    {in_a, in_b, in_c, in_d, in_e, in_f, in_g, in_h} = st;
    in_k = k;
    in_w = w;
    #1;
    chk(in_ready == (!ov || rdy), "R8 in_ready", {255'd0, in_ready}, {255'd0, (!ov || rdy)});
    fo = ov && rdy;
    fi = iv && in_ready;
    if (fo) begin
      if (q.size() > 0) void'(q.pop_front());
      n_out++;
    end
    if (fi) begin
      q.push_back(model(st, k, w));
      n_in++;
    end
    hold_prev = ov && !rdy;
    exp_ov = fi || (ov && !fo);
    @(negedge clk);
    chk(out_valid == exp_ov, "R6 R7 R9 out_valid", {255'd0, out_valid}, {255'd0, exp_ov});
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] iv0;
    void'($urandom(32'h5a17c0de));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", {255'd0, out_valid}, '0);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1 reset in_ready", {255'd0, in_ready}, {255'd0, 1'b1});
    @(negedge clk);

    // directed: known first round of a real digest
    iv0 = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
           32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    step(1'b1, 1'b1, iv0, 32'h428a2f98, 32'h61626380);
    chk(outs() == {32'h5d6aebcd, 32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372,
                   32'hfa2a4622, 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab},
        "R2 R3 R4 known round", outs(), '0);
    // R5: all-zero and all-ones
    step(1'b1, 1'b1, '0, 32'h0, 32'h0);
    step(1'b1, 1'b1, '1, 32'hffffffff, 32'hffffffff);
    step(1'b0, 1'b0, '0, 0, 0);
    // R7 R11: stall while new words are offered
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, rnd256(), $urandom, $urandom);
    step(1'b1, 1'b0, '0, 0, 0);
    step(1'b1, 1'b0, '0, 0, 0);

    // random stalls and gaps
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) != 0, ($urandom % 4) != 0, rnd256(), $urandom, $urandom);

    // drain
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, 0, 0);
    chk(q.size() == 0 && n_in == n_out, "R10 all accepted results delivered once",
        {224'd0, n_out}, {224'd0, n_in});
    chk(out_valid == 1'b0, "R9 idle after drain", {255'd0, out_valid}, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule